// File: doc/BRIEF.md
# Card Station Feed-Cycle Controller

This block sits inside a virtual card reader/punch and owns two 80-column card images. The first is the read station, which holds the card that will be read next. The second is the punch station, which holds the card that was read last and can still be punched. A feed cycle moves the read-station card into the punch station. It does this by copying one 12-bit column per clock, and it pulses a completion strobe when the copy is done. A read request runs a feed cycle and also streams each column to the host as it is copied. A feed-only request runs the same copy without that stream. A punch request overwrites the leading columns of the punch-station image with host data. A stacker request routes the next card that leaves the punch station to the alternate output.

An external loader fills the read-station image through a write port. It marks the deck's final card with a level input, and it announces a fresh deck with a pulse. The block reports not-ready whenever no deck is active. Read and feed requests made while not-ready are dropped. The output consumer reads the punch-station image through its own read port.

Top module: `card_feed_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `rd_stb`, `pun_stb` and `eject_stb` are low and `not_ready` is high.
- R2: A read (`req_op`=0) or feed-only (`req_op`=1) request taken while ready copies all 80 read-station columns into the punch station. `busy` is high from the accepting edge on. `done` pulses for one cycle, set by the 80th edge after the accepting edge, and `busy` falls on that same edge.
- R3: The column index restarts at column 0 for every feed cycle, so a second and later feed copies the complete new card and not a partial one.
- R4: During a read, `rd_stb` is high for 80 cycles, with `rd_col` stepping 0..79 and `rd_data` equal to the read-station column. A feed-only request never raises `rd_stb`.
- R5: A punch (`req_op`=2) with count n writes punch-station columns 0..n-1 from `pun_data`, one per cycle, and leaves the other columns unchanged. A count above 80 is treated as 80. `done` is set by the n-th edge after acceptance, or by the accepting edge itself when n=0.
- R6: Every accepted feed pulses `eject_stb` from the accepting edge. A stacker request (`req_op`=3) completes with `done` on its accepting edge. It makes `eject_alt` high for the next feed only.
- R7: When `card_last` is high at the acceptance of a read or feed, `not_ready` rises on the same edge that sets that feed's `done`.
- R8: While `not_ready` is high, read and feed requests are ignored: no `busy`, no `done`, no eject, and the punch-station image is unchanged.
- R9: A `deck_start` pulse clears `not_ready` on the next edge, and reads then work normally.
- R10: Requests are taken only when idle. A request held high while `busy` is taken on the first edge after `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; held until taken |
| req_op | input | 2 | 0 read, 1 feed-only, 2 punch, 3 stacker |
| req_count | input | 7 | Punch column count (values above 80 clamp to 80) |
| busy | output | 1 | Column sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| not_ready | output | 1 | No active deck |
| deck_start | input | 1 | Pulse: a new deck has been loaded |
| card_last | input | 1 | Read-station card is the last of the deck |
| ld_we | input | 1 | Loader write strobe for the read station |
| ld_col | input | 7 | Loader column index |
| ld_data | input | 12 | Loader column hole pattern |
| rd_stb | output | 1 | Read column valid |
| rd_col | output | 7 | Column index being read |
| rd_data | output | 12 | Column hole pattern being read |
| pun_stb | output | 1 | Punch column being written this cycle |
| pun_col | output | 7 | Column index being punched |
| pun_data | input | 12 | Host punch pattern for `pun_col` (same cycle) |
| out_col | input | 7 | Punch-station read index |
| out_data | output | 12 | Punch-station column at `out_col` |
| eject_stb | output | 1 | Punch-station card leaves toward an output |
| eject_alt | output | 1 | Ejected card goes to the alternate output |

## Verification
Every result is registered, so its timing counts from the clock edge that accepts the request. `eject_stb` and a stacker or zero-count `done` appear on the accepting edge. A punch of n columns sets `done` on the n-th edge after acceptance, and a feed sets it on the 80th edge. Column i of a read stream is visible in the cycle after the i-th edge. The bench samples at falling edges and numbers them from the one just after acceptance, so it expects each result at exactly that index. The last-card flag and the held request are probed at the cycles around the 80th edge. The buffer contents are compared column by column only after the sequence has returned to idle.

// File: rtl/card_feed_pkg.sv
package card_feed_pkg;

   typedef enum logic [1:0] {
      OP_READ  = 2'd0,
      OP_FEED  = 2'd1,
      OP_PUNCH = 2'd2,
      OP_STACK = 2'd3
   } feed_op_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_COPY  = 2'd1,
      ST_PUNCH = 2'd2
   } seq_state_e;

endpackage

// File: rtl/card_buf.sv
module card_buf #(
   parameter int DEPTH = 80,
   parameter int WIDTH = 12,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    wa,
   input  logic [WIDTH-1:0] wd,
   input  logic [AW-1:0]    ra,
   output logic [WIDTH-1:0] rd
);

   localparam bit FULL_RANGE = ((1 << AW) == DEPTH);

   logic [WIDTH-1:0] mem [DEPTH];
   logic             wr_ok;

   generate
      if (FULL_RANGE) begin : g_full
         assign wr_ok = we;
         assign rd    = mem[ra];
      end else begin : g_guard
         assign wr_ok = we && (wa < AW'(DEPTH));
         assign rd    = (ra < AW'(DEPTH)) ? mem[ra] : '0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wa] <= wd;
   end

endmodule

// File: rtl/col_seq.sv
module col_seq
   import card_feed_pkg::*;
#(
   parameter int COLS = 80,
   parameter int IDXW = $clog2(COLS),
   parameter int CNTW = $clog2(COLS + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_copy,
   input  logic            start_punch,
   input  logic [CNTW-1:0] punch_len,
   output seq_state_e      state,
   output logic [IDXW-1:0] col,
   output logic            copy_fin,
   output logic            seq_done
);

   localparam logic [IDXW-1:0] LAST_COL = IDXW'(COLS - 1);

   logic [CNTW-1:0] len_q;
   logic            punch_fin;

   assign copy_fin  = (state == ST_COPY) && (col == LAST_COL);
   assign punch_fin = (state == ST_PUNCH) && ((CNTW'(col) + CNTW'(1)) == len_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         col      <= '0;
         len_q    <= '0;
         seq_done <= 1'b0;
      end else begin
         seq_done <= copy_fin || punch_fin;
         case (state)
            ST_IDLE: begin
               col <= '0;
               if (start_copy) begin
                  state <= ST_COPY;
               end else if (start_punch) begin
                  state <= ST_PUNCH;
                  len_q <= punch_len;
               end
            end
            ST_COPY: begin
               if (copy_fin) begin
                  state <= ST_IDLE;
                  col   <= '0;
               end else begin
                  col <= col + IDXW'(1);
               end
            end
            ST_PUNCH: begin
               if (punch_fin) begin
                  state <= ST_IDLE;
                  col   <= '0;
               end else begin
                  col <= col + IDXW'(1);
               end
            end
            default: begin
               state <= ST_IDLE;
               col   <= '0;
            end
         endcase
      end
   end

endmodule

// File: rtl/card_feed_ctrl.sv
module card_feed_ctrl
   import card_feed_pkg::*;
#(
   parameter int COLS = 80,
   parameter int COLW = 12,
   parameter int IDXW = $clog2(COLS),
   parameter int CNTW = $clog2(COLS + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   input  logic [1:0]      req_op,
   input  logic [CNTW-1:0] req_count,
   output logic            busy,
   output logic            done,
   output logic            not_ready,
   input  logic            deck_start,
   input  logic            card_last,
   input  logic            ld_we,
   input  logic [IDXW-1:0] ld_col,
   input  logic [COLW-1:0] ld_data,
   output logic            rd_stb,
   output logic [IDXW-1:0] rd_col,
   output logic [COLW-1:0] rd_data,
   output logic            pun_stb,
   output logic [IDXW-1:0] pun_col,
   input  logic [COLW-1:0] pun_data,
   input  logic [IDXW-1:0] out_col,
   output logic [COLW-1:0] out_data,
   output logic            eject_stb,
   output logic            eject_alt
);

   localparam logic [CNTW-1:0] MAX_LEN = CNTW'(COLS);

   generate
      if (COLS < 2 || COLW < 1 || CNTW < IDXW) begin : g_bad_cfg
         $error("card_feed_ctrl: unsupported COLS/COLW/CNTW");
      end
   endgenerate

   feed_op_e        op;
   seq_state_e      seq_state;
   logic [IDXW-1:0] seq_col;
   logic            copy_fin, seq_done;
   logic            accept, is_feed, start_copy, start_punch, imm_done;
   logic [CNTW-1:0] punch_len;
   logic            deck_active, alt_q, last_q, rd_mode_q;
   logic            eject_q, eject_alt_q, imm_done_q;
   logic [COLW-1:0] pre_rd_col;
   logic            pp_we;
   logic [COLW-1:0] pp_wd;

   assign op          = feed_op_e'(req_op);
   assign accept      = req_valid && (seq_state == ST_IDLE);
   assign is_feed     = (op == OP_READ) || (op == OP_FEED);
   assign punch_len   = (req_count > MAX_LEN) ? MAX_LEN : req_count;
   assign start_copy  = accept && is_feed && deck_active;
   assign start_punch = accept && (op == OP_PUNCH) && (punch_len != '0);
   assign imm_done    = accept && ((op == OP_STACK) ||
                                   ((op == OP_PUNCH) && (punch_len == '0)));

   col_seq #(.COLS(COLS), .IDXW(IDXW), .CNTW(CNTW)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_copy (start_copy),
      .start_punch(start_punch),
      .punch_len  (punch_len),
      .state      (seq_state),
      .col        (seq_col),
      .copy_fin   (copy_fin),
      .seq_done   (seq_done)
   );

   card_buf #(.DEPTH(COLS), .WIDTH(COLW), .AW(IDXW)) u_read_stn (
      .clk(clk),
      .we (ld_we),
      .wa (ld_col),
      .wd (ld_data),
      .ra (seq_col),
      .rd (pre_rd_col)
   );

   assign pp_we = (seq_state == ST_COPY) || (seq_state == ST_PUNCH);
   assign pp_wd = (seq_state == ST_COPY) ? pre_rd_col : pun_data;

   card_buf #(.DEPTH(COLS), .WIDTH(COLW), .AW(IDXW)) u_punch_stn (
      .clk(clk),
      .we (pp_we),
      .wa (seq_col),
      .wd (pp_wd),
      .ra (out_col),
      .rd (out_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         deck_active <= 1'b0;
         alt_q       <= 1'b0;
         last_q      <= 1'b0;
         rd_mode_q   <= 1'b0;
         eject_q     <= 1'b0;
         eject_alt_q <= 1'b0;
         imm_done_q  <= 1'b0;
      end else begin
         eject_q     <= start_copy;
         eject_alt_q <= start_copy && alt_q;
         imm_done_q  <= imm_done;
         if (start_copy) begin
            last_q    <= card_last;
            rd_mode_q <= (op == OP_READ);
         end
         if (accept && (op == OP_STACK))
            alt_q <= 1'b1;
         else if (start_copy)
            alt_q <= 1'b0;
         if (deck_start)
            deck_active <= 1'b1;
         else if (copy_fin && last_q)
            deck_active <= 1'b0;
      end
   end

   assign busy      = (seq_state != ST_IDLE);
   assign done      = seq_done || imm_done_q;
   assign not_ready = !deck_active;
   assign rd_stb    = (seq_state == ST_COPY) && rd_mode_q;
   assign rd_col    = seq_col;
   assign rd_data   = pre_rd_col;
   assign pun_stb   = (seq_state == ST_PUNCH);
   assign pun_col   = seq_col;
   assign eject_stb = eject_q;
   assign eject_alt = eject_alt_q;

endmodule

// File: rtl/card_feed_chk.sv
module card_feed_chk #(
   parameter int COLS = 80,
   parameter int IDXW = $clog2(COLS)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            busy,
   input logic            done,
   input logic            not_ready,
   input logic            rd_stb,
   input logic [IDXW-1:0] rd_col,
   input logic            pun_stb,
   input logic [IDXW-1:0] pun_col,
   input logic            eject_stb,
   input logic [IDXW-1:0] col_idx
);

   localparam logic [IDXW:0] COL_LIM = (IDXW + 1)'(COLS);

   AST_IDLE_COL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (col_idx == '0)); // R3

   AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done); // R2

   AST_RD_COL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb |-> ({1'b0, rd_col} < COL_LIM)); // R4

   AST_STB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_stb && pun_stb)); // R5

   AST_PUN_COL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      pun_stb |-> ({1'b0, pun_col} < COL_LIM)); // R5

   AST_NR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(not_ready) |-> done); // R7

   AST_FEED_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      eject_stb |-> $past(!not_ready)); // R8

endmodule

bind card_feed_ctrl card_feed_chk #(.COLS(COLS), .IDXW(IDXW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .done     (done),
   .not_ready(not_ready),
   .rd_stb   (rd_stb),
   .rd_col   (rd_col),
   .pun_stb  (pun_stb),
   .pun_col  (pun_col),
   .eject_stb(eject_stb),
   .col_idx  (seq_col)
);

// File: tb/tb_card_feed_ctrl.sv
module tb_card_feed_ctrl;

   localparam int CLK_P = 10;
   localparam int COLS  = 80;
   localparam int COLW  = 12;
   localparam int IDXW  = 7;
   localparam int CNTW  = 7;

   localparam int NPT = 6;
   localparam int PT_CNT [NPT] = '{1, 0, 40, 79, 80, 100};
   localparam int PT_EXP [NPT] = '{1, 0, 40, 79, 80, 80};

   logic            clk = 1'b0;
   logic            rst_n;
   logic            req_valid;
   logic [1:0]      req_op;
   logic [CNTW-1:0] req_count;
   logic            busy, done, not_ready;
   logic            deck_start, card_last;
   logic            ld_we;
   logic [IDXW-1:0] ld_col;
   logic [COLW-1:0] ld_data;
   logic            rd_stb;
   logic [IDXW-1:0] rd_col;
   logic [COLW-1:0] rd_data;
   logic            pun_stb;
   logic [IDXW-1:0] pun_col;
   logic [COLW-1:0] pun_data;
   logic [IDXW-1:0] out_col;
   logic [COLW-1:0] out_data;
   logic            eject_stb, eject_alt;

   int n_chk = 0;
   int n_bad = 0;
   int pseed = 0;

   function automatic logic [COLW-1:0] img(input int s, input int c);
      return COLW'(s * 97 + c * 13 + 11);
   endfunction

   function automatic logic [COLW-1:0] pdat(input int s, input int c);
      return COLW'(s * 211 + c * 3 + 7) ^ 12'h5A5;
   endfunction

   assign pun_data = pdat(pseed, int'(pun_col));

   card_feed_ctrl dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_count(req_count), .busy(busy), .done(done), .not_ready(not_ready),
      .deck_start(deck_start), .card_last(card_last), .ld_we(ld_we),
      .ld_col(ld_col), .ld_data(ld_data), .rd_stb(rd_stb), .rd_col(rd_col),
      .rd_data(rd_data), .pun_stb(pun_stb), .pun_col(pun_col),
      .pun_data(pun_data), .out_col(out_col), .out_data(out_data),
      .eject_stb(eject_stb), .eject_alt(eject_alt)
   );

   always #(CLK_P / 2) clk = ~clk;

   task automatic chk(input int act, input int exp, input string req);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   initial begin
      #(CLK_P * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   task automatic load_card(input int s);
      for (int c = 0; c < COLS; c++) begin
         @(negedge clk);
         ld_we   = 1'b1;
         ld_col  = IDXW'(c);
         ld_data = img(s, c);
      end
      @(negedge clk);
      ld_we = 1'b0;
   endtask

   task automatic out_mism(input int base, input int n, input int ps, output int bad);
      bad = 0;
      for (int c = 0; c < COLS; c++) begin
         out_col = IDXW'(c);
         #1;
         if (out_data !== ((c < n) ? pdat(ps, c) : img(base, c))) bad++;
      end
   endtask

   task automatic pulse_deck();
      @(negedge clk);
      deck_start = 1'b1;
      @(negedge clk);
      deck_start = 1'b0;
   endtask

   // Index i counts falling edges from the one right after the accepting edge.
   task automatic run_op(input logic [1:0] op, input int cnt, input int seed,
                         input int maxc, output int done_at, output int ej,
                         output int eja, output int rd_hits, output int rd_bad,
                         output int pun_hits, output int busy0);
      @(negedge clk);
      req_valid = 1'b1;
      req_op    = op;
      req_count = CNTW'(cnt);
      @(negedge clk);
      req_valid = 1'b0;
      done_at = -1; ej = 0; eja = 0; rd_hits = 0; rd_bad = 0;
      pun_hits = 0; busy0 = 0;
      for (int i = 0; i < maxc; i++) begin
         if (i > 0) @(negedge clk);
         if (i == 0) begin
            busy0 = int'(busy);
            ej    = int'(eject_stb);
            eja   = int'(eject_alt);
         end
         if (done && done_at < 0) done_at = i;
         if (rd_stb) begin
            rd_hits++;
            if (int'(rd_col) != i || rd_data !== img(seed, i)) rd_bad++;
         end
         if (pun_stb) pun_hits++;
      end
   endtask

   initial begin
      int d, e, ea, rh, rb, ph, b0, bad;
      rst_n = 1'b0; req_valid = 1'b0; req_op = 2'd0; req_count = '0;
      deck_start = 1'b0; card_last = 1'b0; ld_we = 1'b0; ld_col = '0;
      ld_data = '0; out_col = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(int'(busy), 0, "R1 busy");
      chk(int'(done), 0, "R1 done");
      chk(int'(not_ready), 1, "R1 not_ready");
      chk(int'(rd_stb) + int'(pun_stb) + int'(eject_stb), 0, "R1 strobes");

      // R9 deck start
      pulse_deck();
      chk(int'(not_ready), 0, "R9 ready after deck_start");

      // R2 R4 R6 read
      load_card(1);
      run_op(2'd0, 0, 1, 82, d, e, ea, rh, rb, ph, b0);
      chk(d, 80, "R2 done cycle");
      chk(b0, 1, "R2 busy");
      chk(e, 1, "R6 eject on feed");
      chk(ea, 0, "R6 eject_alt default");
      chk(rh, 80, "R4 read stream length");
      chk(rb, 0, "R4 read stream content");
      out_mism(1, 0, 0, bad);
      chk(bad, 0, "R2 punch station copy");

      // R3 second feed copies a complete card
      load_card(2);
      run_op(2'd0, 0, 2, 82, d, e, ea, rh, rb, ph, b0);
      chk(d, 80, "R3 second done cycle");
      out_mism(2, 0, 0, bad);
      chk(bad, 0, "R3 second copy complete");

      // R4 feed-only has no read stream
      load_card(3);
      run_op(2'd1, 0, 3, 82, d, e, ea, rh, rb, ph, b0);
      chk(rh, 0, "R4 feed-only no rd_stb");
      out_mism(3, 0, 0, bad);
      chk(bad, 0, "R4 feed-only copy");

      // R6 stacker select
      run_op(2'd3, 0, 0, 3, d, e, ea, rh, rb, ph, b0);
      chk(d, 0, "R6 stacker done");
      load_card(4);
      run_op(2'd1, 0, 4, 82, d, e, ea, rh, rb, ph, b0);
      chk(ea, 1, "R6 alternate eject");
      load_card(5);
      run_op(2'd1, 0, 5, 82, d, e, ea, rh, rb, ph, b0);
      chk(ea, 0, "R6 alternate only once");

      // R5 punch table
      for (int k = 0; k < NPT; k++) begin
         load_card(10 + k);
         run_op(2'd1, 0, 10 + k, 82, d, e, ea, rh, rb, ph, b0);
         pseed = k + 1;
         run_op(2'd2, PT_CNT[k], 0, 85, d, e, ea, rh, rb, ph, b0);
         chk(d, PT_EXP[k], "R5 punch done cycle");
         chk(ph, PT_EXP[k], "R5 punch column count");
         out_mism(10 + k, PT_EXP[k], k + 1, bad);
         chk(bad, 0, "R5 punch overwrite");
      end

      // R10 request held while busy
      load_card(20);
      @(negedge clk);
      req_valid = 1'b1;
      req_op    = 2'd1;
      @(negedge clk);
      req_op = 2'd3;
      for (int i = 0; i < 82; i++) begin
         if (i > 0) @(negedge clk);
         if (i == 40) begin
            chk(int'(busy), 1, "R10 busy while copying");
            chk(int'(done), 0, "R10 held request not taken");
         end
         if (i == 80) begin
            chk(int'(done), 1, "R10 feed done");
            chk(int'(busy), 0, "R10 busy drops");
         end
         if (i == 81) begin
            chk(int'(done), 1, "R10 held stacker taken");
            req_valid = 1'b0;
         end
      end
      load_card(21);
      run_op(2'd1, 0, 21, 82, d, e, ea, rh, rb, ph, b0);
      chk(ea, 1, "R10 held stacker applied");

      // R7 last card
      load_card(30);
      @(negedge clk);
      card_last = 1'b1;
      req_valid = 1'b1;
      req_op    = 2'd0;
      @(negedge clk);
      req_valid = 1'b0;
      card_last = 1'b0;
      for (int i = 0; i < 81; i++) begin
         if (i > 0) @(negedge clk);
         if (i == 79) chk(int'(not_ready), 0, "R7 ready before end");
         if (i == 80) begin
            chk(int'(not_ready), 1, "R7 not_ready at end");
            chk(int'(done), 1, "R7 done with last card");
         end
      end

      // R8 not ready ignores feeds
      load_card(31);
      run_op(2'd0, 0, 31, 90, d, e, ea, rh, rb, ph, b0);
      chk(d, -1, "R8 no done");
      chk(b0, 0, "R8 no busy");
      chk(e, 0, "R8 no eject");
      out_mism(30, 0, 0, bad);
      chk(bad, 0, "R8 punch station unchanged");

      // R9 restart
      pulse_deck();
      chk(int'(not_ready), 0, "R9 ready again");
      run_op(2'd0, 0, 31, 82, d, e, ea, rh, rb, ph, b0);
      chk(d, 80, "R9 read after restart");
      out_mism(31, 0, 0, bad);
      chk(bad, 0, "R9 copy after restart");

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule